// File: doc/BRIEF.md
# Multi-Size Arithmetic Flag Unit

This block is the add/subtract datapath of a processor's integer unit, together with its condition-code register. In one combinational pass it performs add, add-with-extend, subtract, subtract-with-extend, compare or negate on byte, word or longword operands. For the selected size it derives half-carry, negative, zero, overflow and carry. The six-bit flag register captures these on a clock edge. It also accepts an immediate load and immediate AND, OR and XOR, and its contents can be read back through the result port. A user bit is held in the register, and arithmetic never changes it.

The operand called `dst_i` is the destination: add gives dst + src, subtract gives dst - src, and negate gives 0 - dst. Compare forms dst - src only to produce flags. The half-carry is taken four bits below the most significant bit of the active size, which is bit 3, 11 or 27. The extend forms fold the current carry into the sum or difference, and their zero flag can only be cleared. This lets a chain of narrow operations test a wide quantity for zero. Reset clears the flag register, which makes the start state deterministic.

Top module: `flag_arith_unit`

## Requirements
- R1: Size codes are 0 byte, 1 word, 2 or 3 longword. The result is zero-extended above the active size. The flag byte on `flags_o` is H bit 5, U bit 4, N bit 3, Z bit 2, V bit 1, C bit 0, and bits 7:6 read 0.
- R2: Opcodes are 0 add, 1 add-extend, 2 subtract, 3 subtract-extend, 5 negate. The result is dst+src, dst+src+C, dst-src, dst-src-C, or 0-dst, truncated to the size. Operand bits above the size are ignored.
- R3: For non-extend arithmetic, C becomes the carry out of the size's top bit on add, or the borrow on subtract and negate.
- R4: H becomes the carry or borrow out of bit 3, 11 or 27 for byte, word or longword respectively.
- R5: N becomes the top bit of the sized result. For non-extend arithmetic, Z becomes 1 exactly when the sized result is zero.
- R6: V becomes 1 exactly when the signed result does not fit the size.
- R7: For the extend forms (1 and 3), C is the carry or borrow including the old C, and the new Z is the old Z ANDed with result-is-zero.
- R8: Compare (opcode 4) updates the flags exactly as subtract does, and the result output shows dst unchanged (sized).
- R9: Opcode 6 loads `src_i[5:0]` into the flags. Opcodes 8, 9 and 10 AND, OR and XOR `src_i[5:0]` into them. Opcode 7 drives the flag byte onto the result and leaves the flags unchanged.
- R10: Arithmetic opcodes 0 to 5 never change U.
- R11: With `upd_en_i` low, or with opcodes 11 to 15, the flags keep their value. Opcodes 6 and 8 to 15 show sized dst on the result.
- R12: After reset all flags read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 4 | Operation code |
| size_i | input | 2 | Operand size code |
| src_i | input | DATA_W | Source operand / flag immediate |
| dst_i | input | DATA_W | Destination operand |
| upd_en_i | input | 1 | Flag register write enable |
| result_o | output | DATA_W | Combinational sized result |
| flags_o | output | 8 | Flag register byte |

## Verification
Several properties are checked on every cycle: the flags hold while updates are disabled, U survives arithmetic, and N and Z follow the result that was committed. The extend-form zero flag never rises. Compare and flag-store results are checked against their inputs, and the upper bits are checked to be zero for byte operations. Only the bench's reference model can show that the carry, borrow, half-carry and overflow bits are correct at each size boundary, that the extend chains carry across steps, and that the immediate logic operations act on the correct bits.

// File: rtl/fau_pkg.sv
package fau_pkg;

   localparam logic [3:0] OP_ADD  = 4'd0;
   localparam logic [3:0] OP_ADDX = 4'd1;
   localparam logic [3:0] OP_SUB  = 4'd2;
   localparam logic [3:0] OP_SUBX = 4'd3;
   localparam logic [3:0] OP_CMP  = 4'd4;
   localparam logic [3:0] OP_NEG  = 4'd5;
   localparam logic [3:0] OP_LDF  = 4'd6;
   localparam logic [3:0] OP_STF  = 4'd7;
   localparam logic [3:0] OP_ANDF = 4'd8;
   localparam logic [3:0] OP_ORF  = 4'd9;
   localparam logic [3:0] OP_XORF = 4'd10;

   localparam int NUM_SIZES = 3;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_WORD = 2'd1,
      SZ_LONG = 2'd2,
      SZ_ALT  = 2'd3
   } fau_size_e;

   // Packed order fixes the flag byte layout, bit 5 down to bit 0.
   typedef struct packed {
      logic h;
      logic u;
      logic n;
      logic z;
      logic v;
      logic c;
   } fau_flags_t;

   typedef struct packed {
      logic h;
      logic n;
      logic z;
      logic v;
      logic c;
   } fau_arith_t;

   function automatic logic is_arith(input logic [3:0] op);
      return op <= OP_NEG;
   endfunction

   function automatic logic is_extend(input logic [3:0] op);
      return (op == OP_ADDX) || (op == OP_SUBX);
   endfunction

   function automatic logic is_subtract(input logic [3:0] op);
      return (op == OP_SUB) || (op == OP_SUBX) || (op == OP_CMP) || (op == OP_NEG);
   endfunction

   function automatic logic [1:0] lane_index(input logic [1:0] size);
      logic [1:0] idx;
      case (fau_size_e'(size))
         SZ_BYTE: idx = 2'd0;
         SZ_WORD: idx = 2'd1;
         default: idx = 2'd2;
      endcase
      return idx;
   endfunction

endpackage

// File: rtl/fau_lane.sv
module fau_lane #(
   parameter int W = 8
) (
   input  logic [W-1:0] dst_i,
   input  logic [W-1:0] src_i,
   input  logic         cin_i,
   input  logic         sub_i,
   output logic [W-1:0] res_o,
   output fau_pkg::fau_arith_t flg_o
);
   // Half boundary: carry out of bit W-5 lands in bit HB of the low sum.
   localparam int HB = W - 4;

   if (W < 8 || (W % 4) != 0) begin : g_bad_width
      $error("fau_lane: W must be a multiple of 4, at least 8");
   end

   logic [W:0]  full_q;
   logic [HB:0] half_q;
   logic        sign_in;

   always_comb begin
      if (sub_i) begin
         full_q = {1'b0, dst_i} - {1'b0, src_i} - {{W{1'b0}}, cin_i};
         half_q = {1'b0, dst_i[HB-1:0]} - {1'b0, src_i[HB-1:0]} - {{HB{1'b0}}, cin_i};
         sign_in = dst_i[W-1] ^ src_i[W-1];
      end else begin
         full_q = {1'b0, dst_i} + {1'b0, src_i} + {{W{1'b0}}, cin_i};
         half_q = {1'b0, dst_i[HB-1:0]} + {1'b0, src_i[HB-1:0]} + {{HB{1'b0}}, cin_i};
         sign_in = ~(dst_i[W-1] ^ src_i[W-1]);
      end
   end

   assign res_o   = full_q[W-1:0];
   assign flg_o.c = full_q[W];
   assign flg_o.h = half_q[HB];
   assign flg_o.n = full_q[W-1];
   assign flg_o.z = ~|full_q[W-1:0];
   assign flg_o.v = sign_in & (full_q[W-1] ^ dst_i[W-1]);

endmodule

// File: rtl/fau_ccr.sv
module fau_ccr (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 upd_en_i,
   input  logic [3:0]           op_i,
   input  fau_pkg::fau_arith_t  ar_i,
   input  logic [5:0]           imm_i,
   output fau_pkg::fau_flags_t  flags_o
);
   import fau_pkg::*;

   fau_flags_t flg_q;
   fau_flags_t flg_d;
   fau_flags_t imm_f;

   assign imm_f = fau_flags_t'(imm_i);

   always_comb begin
      flg_d = flg_q;
      if (is_arith(op_i)) begin
         flg_d.h = ar_i.h;
         flg_d.n = ar_i.n;
         flg_d.v = ar_i.v;
         flg_d.c = ar_i.c;
         flg_d.z = is_extend(op_i) ? (flg_q.z & ar_i.z) : ar_i.z;
      end else begin
         case (op_i)
            OP_LDF:  flg_d = imm_f;
            OP_ANDF: flg_d = flg_q & imm_f;
            OP_ORF:  flg_d = flg_q | imm_f;
            OP_XORF: flg_d = flg_q ^ imm_f;
            default: flg_d = flg_q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flg_q <= '0;
      end else if (upd_en_i) begin
         flg_q <= flg_d;
      end
   end

   assign flags_o = flg_q;

endmodule

// File: rtl/flag_arith_unit.sv
module flag_arith_unit #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [3:0]        op_i,
   input  logic [1:0]        size_i,
   input  logic [DATA_W-1:0] src_i,
   input  logic [DATA_W-1:0] dst_i,
   input  logic              upd_en_i,
   output logic [DATA_W-1:0] result_o,
   output logic [7:0]        flags_o
);
   import fau_pkg::*;

   localparam int FLAG_W = $bits(fau_flags_t);

   if (DATA_W < 32 || (DATA_W % 4) != 0) begin : g_bad_width
      $error("flag_arith_unit: DATA_W must be a multiple of 4, at least 32");
   end

   logic              neg_sel;
   logic              sub_sel;
   logic              cin;
   logic [1:0]        sel;
   fau_flags_t        flg_cur;
   logic [DATA_W-1:0] lane_res [NUM_SIZES];
   logic [DATA_W-1:0] lane_dst [NUM_SIZES];
   fau_arith_t        lane_flg [NUM_SIZES];

   assign neg_sel = (op_i == OP_NEG);
   assign sub_sel = is_subtract(op_i);
   assign cin     = is_extend(op_i) & flg_cur.c;
   assign sel     = lane_index(size_i);

   for (genvar g = 0; g < NUM_SIZES; g++) begin : g_lane
      localparam int LW = DATA_W >> (NUM_SIZES - 1 - g);
      logic [LW-1:0] l_dst;
      logic [LW-1:0] l_src;
      logic [LW-1:0] l_res;
      fau_arith_t    l_flg;

      assign l_dst = neg_sel ? '0 : dst_i[LW-1:0];
      assign l_src = neg_sel ? dst_i[LW-1:0] : src_i[LW-1:0];

      fau_lane #(.W(LW)) i_lane (
         .dst_i (l_dst),
         .src_i (l_src),
         .cin_i (cin),
         .sub_i (sub_sel),
         .res_o (l_res),
         .flg_o (l_flg)
      );

      assign lane_res[g] = DATA_W'(l_res);
      assign lane_dst[g] = DATA_W'(dst_i[LW-1:0]);
      assign lane_flg[g] = l_flg;
   end

   fau_ccr i_ccr (
      .clk      (clk),
      .rst_n    (rst_n),
      .upd_en_i (upd_en_i),
      .op_i     (op_i),
      .ar_i     (lane_flg[sel]),
      .imm_i    (src_i[FLAG_W-1:0]),
      .flags_o  (flg_cur)
   );

   always_comb begin
      if (is_arith(op_i) && (op_i != OP_CMP)) begin
         result_o = lane_res[sel];
      end else if (op_i == OP_STF) begin
         result_o = DATA_W'(flg_cur);
      end else begin
         result_o = lane_dst[sel];
      end
   end

   assign flags_o = {{(8 - FLAG_W){1'b0}}, flg_cur};

endmodule

// File: rtl/fau_chk.sv
module fau_chk #(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic [3:0]        op_i,
   input logic [1:0]        size_i,
   input logic [DATA_W-1:0] src_i,
   input logic [DATA_W-1:0] dst_i,
   input logic              upd_en_i,
   input logic [DATA_W-1:0] result_o,
   input logic [7:0]        flags_o
);
   import fau_pkg::*;

   function automatic logic top_bit(input logic [DATA_W-1:0] r, input logic [1:0] s);
      case (s)
         2'd0:    return r[DATA_W/4-1];
         2'd1:    return r[DATA_W/2-1];
         default: return r[DATA_W-1];
      endcase
   endfunction

   function automatic logic [DATA_W-1:0] sized(input logic [DATA_W-1:0] d, input logic [1:0] s);
      case (s)
         2'd0:    return {{(DATA_W - DATA_W/4){1'b0}}, d[DATA_W/4-1:0]};
         2'd1:    return {{(DATA_W - DATA_W/2){1'b0}}, d[DATA_W/2-1:0]};
         default: return d;
      endcase
   endfunction

   AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_en_i |=> $stable(flags_o)); // R11

   AST_USER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_en_i && is_arith(op_i)) |=> (flags_o[4] == $past(flags_o[4]))); // R10

   AST_N_FROM_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_en_i && is_arith(op_i) && op_i != OP_CMP) |=> (flags_o[3] == $past(top_bit(result_o, size_i)))); // R5

   AST_Z_FROM_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_en_i && (op_i == OP_ADD || op_i == OP_SUB || op_i == OP_NEG)) |=> (flags_o[2] == ($past(result_o) == '0))); // R5

   AST_Z_NEVER_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_en_i && is_extend(op_i) && !flags_o[2]) |=> !flags_o[2]); // R7

   AST_CMP_KEEPS_DST: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == OP_CMP) |-> (result_o == sized(dst_i, size_i))); // R8

   AST_STORE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == OP_STF) |-> (result_o == DATA_W'(flags_o))); // R9

   AST_LOAD_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_en_i && op_i == OP_LDF) |=> (flags_o[5:0] == $past(src_i[5:0]))); // R9

   AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (size_i == 2'd0) |-> (result_o[DATA_W-1:DATA_W/4] == '0)); // R1

   AST_SPARE_BITS: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |-> (flags_o[7:6] == 2'b00)); // R1

endmodule

bind flag_arith_unit fau_chk #(.DATA_W(DATA_W)) i_fau_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .op_i     (op_i),
   .size_i   (size_i),
   .src_i    (src_i),
   .dst_i    (dst_i),
   .upd_en_i (upd_en_i),
   .result_o (result_o),
   .flags_o  (flags_o)
);

// File: tb/test_flag_arith_unit.sv
`timescale 1ns/1ps
module test_flag_arith_unit;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [3:0]    op = 4'd0;
   logic [1:0]    size = 2'd0;
   logic [DW-1:0] src = '0;
   logic [DW-1:0] dst = '0;
   logic          en = 1'b0;
   logic [DW-1:0] res;
   logic [7:0]    fl;

   int   n_chk = 0;
   int   n_bad = 0;
   logic [5:0] m_fl = '0;

   always #5 clk = ~clk;

   flag_arith_unit #(.DATA_W(DW)) i_flag_arith_unit (
      .clk(clk), .rst_n(rst_n), .op_i(op), .size_i(size), .src_i(src),
      .dst_i(dst), .upd_en_i(en), .result_o(res), .flags_o(fl));

   task automatic check(input string req, input longint got, input longint exp, input string what);
      n_chk++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
      end
   endtask

   function automatic longint sx(input longint v, input int w);
      return (v >= (longint'(1) << (w - 1))) ? v - (longint'(1) << w) : v;
   endfunction

   function automatic string flag_req(input int b, input logic [3:0] o, input logic e);
      if (!e || o > 4'd10 || o == 4'd7) return "R11";
      if (o >= 4'd6) return "R9";
      if (o == 4'd4) return "R8";
      case (b)
         5: return "R4";
         4: return "R10";
         3: return "R5";
         2: return (o == 4'd1 || o == 4'd3) ? "R7" : "R5";
         1: return "R6";
         default: return (o == 4'd1 || o == 4'd3) ? "R7" : "R3";
      endcase
   endfunction

   task automatic run_op(input logic [3:0] o, input logic [1:0] s,
                         input logic [31:0] av, input logic [31:0] bv, input logic e);
      int w;
      longint mask, hm, aa, bb, x, y, cin, full, r, sres, lim, er;
      logic hh, nn, zz, vv, cc, ar, ext, sb;
      logic [5:0] nf;
      string rreq;
      w    = (s == 2'd0) ? 8 : (s == 2'd1) ? 16 : 32;
      mask = (longint'(1) << w) - 1;
      hm   = (longint'(1) << (w - 4)) - 1;
      aa   = longint'(av) & mask;
      bb   = longint'(bv) & mask;
      ar   = (o <= 4'd5);
      ext  = (o == 4'd1 || o == 4'd3);
      sb   = (o >= 4'd2 && o <= 4'd5);
      cin  = ext ? longint'(m_fl[0]) : 0;
      x    = (o == 4'd5) ? 0 : bb;
      y    = (o == 4'd5) ? bb : aa;
      if (sb) begin
         full = x - y - cin;
         cc   = (x < y + cin);
         hh   = ((x & hm) < (y & hm) + cin);
         sres = sx(x, w) - sx(y, w) - cin;
      end else begin
         full = x + y + cin;
         cc   = ((full >> w) & 1) != 0;
         hh   = ((((x & hm) + (y & hm) + cin) >> (w - 4)) & 1) != 0;
         sres = sx(x, w) + sx(y, w) + cin;
      end
      r   = full & mask;
      lim = longint'(1) << (w - 1);
      vv  = (sres >= lim) || (sres < -lim);
      nn  = ((r >> (w - 1)) & 1) != 0;
      zz  = ext ? (m_fl[2] && r == 0) : (r == 0);
      if (ar && o != 4'd4) begin er = r; rreq = "R2"; end
      else if (o == 4'd7) begin er = longint'(m_fl); rreq = "R9"; end
      else begin er = bb; rreq = (o == 4'd4) ? "R8" : "R11"; end
      nf = m_fl;
      if (e) begin
         if (ar) nf = {hh, m_fl[4], nn, zz, vv, cc};
         else case (o)
            4'd6:    nf = av[5:0];
            4'd8:    nf = m_fl & av[5:0];
            4'd9:    nf = m_fl | av[5:0];
            4'd10:   nf = m_fl ^ av[5:0];
            default: nf = m_fl;
         endcase
      end
      @(negedge clk);
      op = o; size = s; src = av; dst = bv; en = e;
      #1;
      check(rreq, longint'(res) & mask, er, $sformatf("result op %0d size %0d", o, s));
      check("R1", longint'(res) >> w, 0, "bits above size");
      @(posedge clk);
      #1;
      for (int b = 0; b < 6; b++)
         check(flag_req(b, o, e), longint'(fl[b]), longint'(nf[b]),
               $sformatf("flag bit %0d op %0d size %0d", b, o, s));
      check("R1", longint'(fl[7:6]), 0, "spare flag bits");
      m_fl = nf;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL R11 watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      check("R12", longint'(fl), 0, "flags after reset");
      // R2 R3 R4 R5 R6 add corners at each size
      run_op(4'd0, 2'd0, 32'h1, 32'h0F, 1'b1);
      run_op(4'd0, 2'd1, 32'h1, 32'h0FFF, 1'b1);
      run_op(4'd0, 2'd2, 32'h1, 32'h0FFF_FFFF, 1'b1);
      run_op(4'd0, 2'd0, 32'h1, 32'h7F, 1'b1);
      run_op(4'd0, 2'd0, 32'h1, 32'hFF, 1'b1);
      run_op(4'd0, 2'd0, 32'hFFFF_FF01, 32'hABCD_00FE, 1'b1);
      run_op(4'd0, 2'd1, 32'h0000_8000, 32'h0000_8000, 1'b1);
      // subtract and negate borrows
      run_op(4'd2, 2'd0, 32'h1, 32'h0, 1'b1);
      run_op(4'd2, 2'd1, 32'h1, 32'h1000, 1'b1);
      run_op(4'd2, 2'd2, 32'h1, 32'h8000_0000, 1'b1);
      run_op(4'd5, 2'd0, 32'h0, 32'h80, 1'b1);
      run_op(4'd5, 2'd1, 32'h0, 32'h0, 1'b1);
      run_op(4'd5, 2'd2, 32'h0, 32'h1, 1'b1);
      run_op(4'd5, 2'd3, 32'h0, 32'h10, 1'b1);
      // R7 extend chains
      run_op(4'd0, 2'd2, 32'h1, 32'hFFFF_FFFF, 1'b1);
      run_op(4'd1, 2'd2, 32'hFFFF_FFFF, 32'h0, 1'b1);
      run_op(4'd1, 2'd0, 32'h0, 32'h1, 1'b1);
      run_op(4'd1, 2'd0, 32'h0, 32'h0, 1'b1);
      run_op(4'd6, 2'd0, 32'h05, 32'h0, 1'b1);
      run_op(4'd3, 2'd1, 32'h0, 32'h1, 1'b1);
      run_op(4'd3, 2'd1, 32'h0, 32'h0, 1'b1);
      // R8 compare
      run_op(4'd4, 2'd0, 32'h5, 32'hFF05, 1'b1);
      run_op(4'd4, 2'd2, 32'h8000_0000, 32'h1, 1'b1);
      // R9 R10 flag register operations
      run_op(4'd6, 2'd0, 32'h3F, 32'h0, 1'b1);
      run_op(4'd0, 2'd0, 32'h1, 32'h1, 1'b1);
      run_op(4'd8, 2'd0, 32'h15, 32'h0, 1'b1);
      run_op(4'd9, 2'd0, 32'h20, 32'h0, 1'b1);
      run_op(4'd10, 2'd0, 32'h3F, 32'h0, 1'b1);
      run_op(4'd7, 2'd2, 32'h0, 32'h1234, 1'b1);
      // R11 disabled update and unused opcodes
      run_op(4'd0, 2'd0, 32'hFF, 32'hFF, 1'b0);
      run_op(4'd6, 2'd0, 32'h00, 32'h0, 1'b0);
      run_op(4'd12, 2'd1, 32'h3F, 32'hBEEF_1234, 1'b1);
      run_op(4'd15, 2'd2, 32'h3F, 32'h0, 1'b1);
      for (int i = 0; i < 600; i++) begin
         logic [31:0] ra, rb, sel;
         ra  = $urandom;
         rb  = $urandom;
         sel = $urandom;
         if (sel[9:8] == 2'd0) ra = {ra[31:28], 28'h0};
         run_op(sel[3:0], sel[5:4], ra, rb, sel[7:6] != 2'd0);
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule